// File: doc/BRIEF.md
# Variable-Partition Hole Allocator

This block keeps a small table of free memory regions ("holes"). Each entry holds a start address, a size and a valid bit. An allocation request gives a size and a placement policy. The block walks the table one entry per clock, carves the request out of the hole it picks, and returns the start address of the carved region. If no hole is large enough, it answers with a no-fit status. A release request hands a region back. The region is joined to any hole that ends exactly where it begins, to any hole that begins exactly where it ends, or to both. If it touches neither, it occupies an empty slot.

Allocation and release share one sequencer. A request is accepted only while the block is idle. The result appears together with a single-cycle completion pulse. The table is empty after reset, so a memory map is described by releasing regions into it. First-fit can be asked to continue from the slot that served the previous first-fit grant instead of from slot 0, which gives next-fit behaviour.

Top module: `hole_alloc`

## Requirements
- R1: After a synchronous reset the table holds no holes, `busy`, `done` and `grant` are low, and any allocation answers no-fit.
- R2: Policy code 2'b00 with `next_fit` low selects first-fit. The scan starts at slot 0, the first valid hole with size at least the request wins, and the scan stops there.
- R3: Policy 2'b00 with `next_fit` high starts the scan at the slot of the most recent first-fit grant and wraps past the last slot. Every first-fit grant records its slot, whatever the value of `next_fit`.
- R4: Policy 2'b01 selects best-fit. All slots are scanned and the smallest hole that fits wins; on equal sizes the lower slot wins.
- R5: Policy 2'b10 or 2'b11 selects worst-fit. All slots are scanned and the largest hole that fits wins; on equal sizes the lower slot wins.
- R6: A grant returns the hole's start address in `result_addr`. The hole keeps the remainder: its start moves up by the request and its size shrinks by the request.
- R7: A grant that uses a hole exactly leaves no zero-size entry. The slot becomes empty and can be reused by a later release.
- R8: When no valid hole is large enough, or the request size is zero, `grant` is low at completion and the table is unchanged.
- R9: A released region merges with a hole ending at its base, with a hole starting at its end, or with both into one hole. A granted release reports the start of the resulting hole in `result_addr`.
- R10: A release that touches no hole fills the lowest empty slot. With no empty slot, or with size zero, it completes with `grant` low and changes nothing.
- R11: `done` is high for exactly one cycle per accepted request. `busy` is high from acceptance until the cycle before `done`, and lasts at most ENTRIES+1 cycles. Requests seen while `busy` is high are ignored. When both request inputs are high while idle, the allocation is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_req | input | 1 | Allocation request, accepted while idle |
| alloc_size | input | ADDR_W | Requested size |
| alloc_policy | input | 2 | 00 first-fit, 01 best-fit, 1x worst-fit |
| next_fit | input | 1 | First-fit starts at slot of previous first-fit grant |
| free_req | input | 1 | Release request, accepted while idle |
| free_base | input | ADDR_W | Start of released region |
| free_size | input | ADDR_W | Size of released region |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| grant | output | 1 | Outcome of the completed request (1 = success) |
| result_addr | output | ADDR_W | Granted start address, or start of merged hole |

## Verification
The same five-hole map of sizes 100, 500, 200, 300 and 600 is loaded under each policy and given the request sequence 212, 417, 112, 426. Only best-fit places all four. First-fit and worst-fit pick different holes and both reject 426, so each address separates the policies. Further allocations after the best-fit run expose the remainders left behind.

Directed cases cover the rest:
- Two-hole maps show the effect of `next_fit` and of tie-breaking.
- Releases of neighbouring regions exercise merging on one side and on both sides.
- A full table shows rejection, and an exact-size grant shows slot reuse.
- A release pulsed while busy must leave no trace.

// File: rtl/hole_alloc_pkg.sv
package hole_alloc_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_COMMIT} seq_state_e;

  typedef enum logic [1:0] {PK_FIRST, PK_BEST, PK_WORST} pick_e;

  function automatic pick_e decode_policy(input logic [1:0] code);
    if (code[1])      return PK_WORST;
    else if (code[0]) return PK_BEST;
    else              return PK_FIRST;
  endfunction

endpackage

// File: rtl/hole_table.sv
module hole_table #(
  parameter int ADDR_W  = 16,
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] rd_start,
  output logic [ADDR_W-1:0] rd_size,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_start,
  input  logic [ADDR_W-1:0] wr_size,
  input  logic              clr_en,
  input  logic [IDX_W-1:0]  clr_idx
);

  logic [ENTRIES-1:0] vld_q;
  logic [ADDR_W-1:0]  start_mem [ENTRIES];
  logic [ADDR_W-1:0]  size_mem  [ENTRIES];

  // payload kept in reset-free storage; only valid bits are reset
  always_ff @(posedge clk) begin
    if (wr_en) begin
      start_mem[wr_idx] <= wr_start;
      size_mem[wr_idx]  <= wr_size;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
    end else begin
      if (wr_en)  vld_q[wr_idx]  <= wr_valid;
      if (clr_en) vld_q[clr_idx] <= 1'b0;
    end
  end

  assign rd_valid = vld_q[rd_idx];
  assign rd_start = start_mem[rd_idx];
  assign rd_size  = size_mem[rd_idx];

endmodule

// File: rtl/hole_pick.sv
module hole_pick
  import hole_alloc_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  pick_e             pick,
  input  logic              cand_valid,
  input  logic [ADDR_W-1:0] cand_size,
  input  logic [ADDR_W-1:0] need,
  input  logic              have_sel,
  input  logic [ADDR_W-1:0] sel_size,
  output logic              take
);

  logic fits;
  assign fits = cand_valid && (need != '0) && (cand_size >= need);

  // strict comparisons keep the earlier slot on equal sizes
  always_comb begin
    unique case (pick)
      PK_BEST:  take = fits && (!have_sel || (cand_size < sel_size));
      PK_WORST: take = fits && (!have_sel || (cand_size > sel_size));
      default:  take = fits && !have_sel;
    endcase
  end

endmodule

// File: rtl/hole_adjacency.sv
module hole_adjacency #(
  parameter int ADDR_W = 16
) (
  input  logic              cand_valid,
  input  logic [ADDR_W-1:0] cand_start,
  input  logic [ADDR_W-1:0] cand_size,
  input  logic [ADDR_W-1:0] rel_base,
  input  logic [ADDR_W-1:0] rel_size,
  output logic              ends_at_base,
  output logic              starts_at_end,
  output logic              is_empty
);

  assign ends_at_base  = cand_valid && ((cand_start + cand_size) == rel_base);
  assign starts_at_end = cand_valid && (cand_start == (rel_base + rel_size));
  assign is_empty      = !cand_valid;

endmodule

// File: rtl/hole_alloc.sv
module hole_alloc
  import hole_alloc_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int ENTRIES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc_req,
  input  logic [ADDR_W-1:0] alloc_size,
  input  logic [1:0]        alloc_policy,
  input  logic              next_fit,
  input  logic              free_req,
  input  logic [ADDR_W-1:0] free_base,
  input  logic [ADDR_W-1:0] free_size,
  output logic              busy,
  output logic              done,
  output logic              grant,
  output logic [ADDR_W-1:0] result_addr
);

  localparam int IDX_W = $clog2(ENTRIES);
  localparam int CNT_W = IDX_W + 1;
  localparam logic [CNT_W-1:0] ENT_C  = CNT_W'(ENTRIES);
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(ENTRIES - 1);

  seq_state_e        state_q;
  logic              op_alloc_q;
  pick_e             pick_q;
  logic [ADDR_W-1:0] need_q, rel_base_q, rel_size_q;
  logic [IDX_W-1:0]  start_q, rover_q;
  logic [CNT_W-1:0]  cnt_q;

  logic              sel_q;
  logic [IDX_W-1:0]  sel_idx_q;
  logic [ADDR_W-1:0] sel_start_q, sel_size_q;

  logic              prev_q, next_q, empty_q;
  logic [IDX_W-1:0]  prev_idx_q, next_idx_q, empty_idx_q;
  logic [ADDR_W-1:0] prev_start_q, prev_size_q, next_size_q;

  logic [CNT_W-1:0]  idx_sum, idx_wrap;
  logic [IDX_W-1:0]  scan_idx;
  logic              rd_valid;
  logic [ADDR_W-1:0] rd_start, rd_size;
  logic              take, adj_prev, adj_next, adj_empty, last_slot;

  logic              wr_en, wr_valid, clr_en;
  logic [IDX_W-1:0]  wr_idx, clr_idx;
  logic [ADDR_W-1:0] wr_start, wr_size;

  assign idx_sum   = {1'b0, start_q} + cnt_q;
  assign idx_wrap  = (idx_sum >= ENT_C) ? (idx_sum - ENT_C) : idx_sum;
  assign scan_idx  = idx_wrap[IDX_W-1:0];
  assign last_slot = (cnt_q == LAST_C);
  assign busy      = (state_q != ST_IDLE);

  hole_table #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) u_table (
    .clk(clk), .rst(rst),
    .rd_idx(scan_idx), .rd_valid(rd_valid), .rd_start(rd_start), .rd_size(rd_size),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid),
    .wr_start(wr_start), .wr_size(wr_size),
    .clr_en(clr_en), .clr_idx(clr_idx)
  );

  hole_pick #(.ADDR_W(ADDR_W)) u_pick (
    .pick(pick_q), .cand_valid(rd_valid), .cand_size(rd_size),
    .need(need_q), .have_sel(sel_q), .sel_size(sel_size_q), .take(take)
  );

  hole_adjacency #(.ADDR_W(ADDR_W)) u_adj (
    .cand_valid(rd_valid), .cand_start(rd_start), .cand_size(rd_size),
    .rel_base(rel_base_q), .rel_size(rel_size_q),
    .ends_at_base(adj_prev), .starts_at_end(adj_next), .is_empty(adj_empty)
  );

  // table update, only in the commit cycle
  always_comb begin
    wr_en = 1'b0; wr_idx = '0; wr_valid = 1'b0; wr_start = '0; wr_size = '0;
    clr_en = 1'b0; clr_idx = next_idx_q;
    if (state_q == ST_COMMIT) begin
      if (op_alloc_q) begin
        if (sel_q) begin
          wr_en    = 1'b1;
          wr_idx   = sel_idx_q;
          wr_start = sel_start_q + need_q;
          wr_size  = sel_size_q - need_q;
          wr_valid = (sel_size_q != need_q);
        end
      end else if (rel_size_q != '0) begin
        if (prev_q) begin
          wr_en    = 1'b1;
          wr_idx   = prev_idx_q;
          wr_valid = 1'b1;
          wr_start = prev_start_q;
          wr_size  = prev_size_q + rel_size_q + (next_q ? next_size_q : '0);
          clr_en   = next_q;
        end else if (next_q) begin
          wr_en    = 1'b1;
          wr_idx   = next_idx_q;
          wr_valid = 1'b1;
          wr_start = rel_base_q;
          wr_size  = next_size_q + rel_size_q;
        end else if (empty_q) begin
          wr_en    = 1'b1;
          wr_idx   = empty_idx_q;
          wr_valid = 1'b1;
          wr_start = rel_base_q;
          wr_size  = rel_size_q;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      done        <= 1'b0;
      grant       <= 1'b0;
      result_addr <= '0;
      rover_q     <= '0;
      op_alloc_q  <= 1'b0;
      pick_q      <= PK_FIRST;
      need_q      <= '0;
      rel_base_q  <= '0;
      rel_size_q  <= '0;
      start_q     <= '0;
      cnt_q       <= '0;
      sel_q       <= 1'b0;
      sel_idx_q   <= '0;
      sel_start_q <= '0;
      sel_size_q  <= '0;
      prev_q      <= 1'b0;
      next_q      <= 1'b0;
      empty_q     <= 1'b0;
      prev_idx_q  <= '0;
      next_idx_q  <= '0;
      empty_idx_q <= '0;
      prev_start_q <= '0;
      prev_size_q <= '0;
      next_size_q <= '0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          cnt_q   <= '0;
          sel_q   <= 1'b0;
          prev_q  <= 1'b0;
          next_q  <= 1'b0;
          empty_q <= 1'b0;
          if (alloc_req) begin
            op_alloc_q <= 1'b1;
            need_q     <= alloc_size;
            pick_q     <= decode_policy(alloc_policy);
            start_q    <= (decode_policy(alloc_policy) == PK_FIRST && next_fit) ? rover_q : '0;
            state_q    <= ST_SCAN;
          end else if (free_req) begin
            op_alloc_q <= 1'b0;
            rel_base_q <= free_base;
            rel_size_q <= free_size;
            start_q    <= '0;
            state_q    <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          cnt_q <= cnt_q + 1'b1;
          if (op_alloc_q) begin
            if (take) begin
              sel_q       <= 1'b1;
              sel_idx_q   <= scan_idx;
              sel_start_q <= rd_start;
              sel_size_q  <= rd_size;
            end
            if (last_slot || (pick_q == PK_FIRST && take)) state_q <= ST_COMMIT;
          end else begin
            if (adj_prev && !prev_q) begin
              prev_q       <= 1'b1;
              prev_idx_q   <= scan_idx;
              prev_start_q <= rd_start;
              prev_size_q  <= rd_size;
            end
            if (adj_next && !next_q) begin
              next_q      <= 1'b1;
              next_idx_q  <= scan_idx;
              next_size_q <= rd_size;
            end
            if (adj_empty && !empty_q) begin
              empty_q     <= 1'b1;
              empty_idx_q <= scan_idx;
            end
            if (last_slot) state_q <= ST_COMMIT;
          end
        end
        ST_COMMIT: begin
          state_q <= ST_IDLE;
          done    <= 1'b1;
          if (op_alloc_q) begin
            grant <= sel_q;
            if (sel_q) begin
              result_addr <= sel_start_q;
              if (pick_q == PK_FIRST) rover_q <= sel_idx_q;
            end
          end else begin
            grant <= (rel_size_q != '0) && (prev_q || next_q || empty_q);
            result_addr <= prev_q ? prev_start_q : rel_base_q;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/hole_alloc_chk.sv
module hole_alloc_chk #(
  parameter int ADDR_W  = 16,
  parameter int ENTRIES = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              alloc_req,
  input logic              free_req,
  input logic [ADDR_W-1:0] alloc_size,
  input logic              busy,
  input logic              done,
  input logic              grant
);

  localparam int BW = $clog2(ENTRIES + 4) + 1;

  logic [BW-1:0] busy_cycles;
  logic          zero_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_cycles <= '0;
      zero_req    <= 1'b0;
    end else begin
      busy_cycles <= busy ? busy_cycles + 1'b1 : '0;
      if (!busy && (alloc_req || free_req))
        zero_req <= alloc_req && (alloc_size == '0);
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R11
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(busy) && !busy)); // R11
  AST_BUSY_ENDS_IN_DONE: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done); // R11
  AST_SCAN_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    busy |-> (busy_cycles <= BW'(ENTRIES))); // R11
  AST_ZERO_SIZE_NOFIT: assert property (@(posedge clk) disable iff (rst)
    (done && zero_req) |-> !grant); // R8

endmodule

bind hole_alloc hole_alloc_chk #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) u_hole_alloc_chk (
  .clk(clk), .rst(rst), .alloc_req(alloc_req), .free_req(free_req),
  .alloc_size(alloc_size), .busy(busy), .done(done), .grant(grant)
);

// File: tb/hole_alloc_bench.sv
module hole_alloc_bench;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic alloc_req = 1'b0, next_fit = 1'b0, free_req = 1'b0;
  logic [AW-1:0] alloc_size = '0, free_base = '0, free_size = '0;
  logic [1:0] alloc_policy = 2'b00;
  logic busy, done, grant;
  logic [AW-1:0] result_addr;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hole_alloc #(.ADDR_W(AW), .ENTRIES(8)) u_hole_alloc (
    .clk(clk), .rst(rst), .alloc_req(alloc_req), .alloc_size(alloc_size),
    .alloc_policy(alloc_policy), .next_fit(next_fit), .free_req(free_req),
    .free_base(free_base), .free_size(free_size), .busy(busy), .done(done),
    .grant(grant), .result_addr(result_addr)
  );

  typedef struct packed {
    logic        reload;
    logic [1:0]  pol;
    logic [15:0] size;
    logic        exp_g;
    logic [15:0] exp_a;
  } vec_t;

  // hole map for reload: starts 0,1000,..,4000 sizes 100,500,200,300,600
  localparam vec_t VECS [12] = '{
    '{1'b1, 2'b00, 16'd212, 1'b1, 16'd1000},  // R2
    '{1'b0, 2'b00, 16'd417, 1'b1, 16'd4000},
    '{1'b0, 2'b00, 16'd112, 1'b1, 16'd1212},
    '{1'b0, 2'b00, 16'd426, 1'b0, 16'd0},     // R8
    '{1'b1, 2'b10, 16'd212, 1'b1, 16'd4000},  // R5
    '{1'b0, 2'b10, 16'd417, 1'b1, 16'd1000},
    '{1'b0, 2'b10, 16'd112, 1'b1, 16'd4212},
    '{1'b0, 2'b10, 16'd426, 1'b0, 16'd0},
    '{1'b1, 2'b01, 16'd212, 1'b1, 16'd3000},  // R4
    '{1'b0, 2'b01, 16'd417, 1'b1, 16'd1000},
    '{1'b0, 2'b01, 16'd112, 1'b1, 16'd2000},
    '{1'b0, 2'b01, 16'd426, 1'b1, 16'd4000}
  };

  localparam int HOLE_SZ [5] = '{100, 500, 200, 300, 600};

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; alloc_req = 1'b0; free_req = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_done(output bit g, output int a);
    int t = 0;
    while (!done && t < 40) begin
      @(negedge clk);
      t++;
    end
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL R11: actual no done expected done");
    end
    g = grant;
    a = int'(result_addr);
  endtask

  task automatic do_alloc(input logic [1:0] pol, input bit nf, input int sz,
                          output bit g, output int a);
    @(negedge clk);
    alloc_req = 1'b1; alloc_policy = pol; next_fit = nf; alloc_size = AW'(sz);
    @(negedge clk);
    alloc_req = 1'b0;
    wait_done(g, a);
  endtask

  task automatic do_free(input int base, input int sz, output bit g, output int a);
    @(negedge clk);
    free_req = 1'b1; free_base = AW'(base); free_size = AW'(sz);
    @(negedge clk);
    free_req = 1'b0;
    wait_done(g, a);
  endtask

  task automatic load_map();
    bit g; int a;
    do_reset();
    for (int i = 0; i < 5; i++) do_free(1000 * i, HOLE_SZ[i], g, a);
  endtask

  task automatic expect_alloc(input string tag, input logic [1:0] pol, input bit nf,
                              input int sz, input bit eg, input int ea);
    bit g; int a;
    do_alloc(pol, nf, sz, g, a);
    check(g == eg, tag, g, eg);
    if (eg) check(a == ea, tag, a, ea);
  endtask

  task automatic expect_free(input string tag, input int base, input int sz,
                             input bit eg, input int ea);
    bit g; int a;
    do_free(base, sz, g, a);
    check(g == eg, tag, g, eg);
    if (eg) check(a == ea, tag, a, ea);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++; n_checks++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
    $finish;
  end

  initial begin
    // R1: reset state
    do_reset();
    @(negedge clk);
    check(busy == 1'b0, "R1 busy", busy, 0);
    check(done == 1'b0, "R1 done", done, 0);
    check(grant == 1'b0, "R1 grant", grant, 0);
    expect_alloc("R1 empty table", 2'b00, 1'b0, 1, 1'b0, 0);

    // R2 R4 R5 R6 R8: table-driven policy runs
    foreach (VECS[i]) begin
      if (VECS[i].reload) load_map();
      expect_alloc($sformatf("R6 vec %0d", i), VECS[i].pol, 1'b0,
                   int'(VECS[i].size), VECS[i].exp_g, int'(VECS[i].exp_a));
    end
    // R6: best-fit remainders are 100,83,88,88,174 (last at 4426)
    expect_alloc("R6 remainder", 2'b11, 1'b0, 174, 1'b1, 4426);
    expect_alloc("R8 no fit", 2'b10, 1'b0, 101, 1'b0, 0);
    expect_alloc("R8 zero size", 2'b01, 1'b0, 0, 1'b0, 0);

    // R3: next-fit continues from last first-fit slot
    do_reset();
    expect_free("R10 slot0", 0, 100, 1'b1, 0);
    expect_free("R10 slot1", 1000, 100, 1'b1, 1000);
    expect_alloc("R3 a", 2'b00, 1'b1, 60, 1'b1, 0);
    expect_alloc("R3 b", 2'b00, 1'b0, 50, 1'b1, 1000);
    expect_alloc("R3 resume", 2'b00, 1'b1, 30, 1'b1, 1050);
    expect_alloc("R2 restart", 2'b00, 1'b0, 30, 1'b1, 60);

    // R4 R5: ties go to lower slot
    do_reset();
    expect_free("R10 a", 0, 50, 1'b1, 0);
    expect_free("R10 b", 500, 50, 1'b1, 500);
    expect_alloc("R4 tie", 2'b01, 1'b0, 10, 1'b1, 0);
    do_reset();
    expect_free("R10 a", 0, 50, 1'b1, 0);
    expect_free("R10 b", 500, 50, 1'b1, 500);
    expect_alloc("R5 tie", 2'b10, 1'b0, 10, 1'b1, 0);

    // R9: merge both sides, then one side
    do_reset();
    expect_free("R10 lo", 100, 50, 1'b1, 100);
    expect_free("R10 hi", 200, 50, 1'b1, 200);
    expect_free("R9 both", 150, 50, 1'b1, 100);
    expect_alloc("R9 merged", 2'b00, 1'b0, 150, 1'b1, 100);
    expect_alloc("R7 emptied", 2'b00, 1'b0, 1, 1'b0, 0);
    expect_free("R10 x", 300, 20, 1'b1, 300);
    expect_free("R9 before", 280, 20, 1'b1, 280);
    expect_free("R9 after", 320, 10, 1'b1, 280);
    expect_alloc("R9 joined", 2'b01, 1'b0, 50, 1'b1, 280);

    // R10 R7: full table, exact grant frees a slot
    do_reset();
    for (int i = 0; i < 8; i++) expect_free("R10 fill", 1000 * i, 100, 1'b1, 1000 * i);
    expect_free("R10 full", 9000, 100, 1'b0, 0);
    expect_free("R10 zero", 9500, 0, 1'b0, 0);
    expect_alloc("R7 exact", 2'b00, 1'b0, 100, 1'b1, 0);
    expect_free("R7 reuse", 9000, 100, 1'b1, 9000);
    expect_free("R9 full merge", 7100, 50, 1'b1, 7000);
    expect_alloc("R9 grown", 2'b10, 1'b0, 150, 1'b1, 7000);

    // R11: done pulse width and ignored release while busy
    do_reset();
    begin
      bit g; int a;
      @(negedge clk);
      alloc_req = 1'b1; alloc_policy = 2'b00; next_fit = 1'b0; alloc_size = 16'd10;
      @(negedge clk);
      alloc_req = 1'b0;
      check(busy == 1'b1, "R11 busy", busy, 1);
      free_req = 1'b1; free_base = 16'd0; free_size = 16'd100;
      @(negedge clk);
      free_req = 1'b0;
      wait_done(g, a);
      check(g == 1'b0, "R11 nofit", g, 0);
      @(negedge clk);
      check(done == 1'b0, "R11 pulse", done, 0);
      check(busy == 1'b0, "R11 idle", busy, 0);
    end
    expect_alloc("R11 ignored release", 2'b00, 1'b0, 100, 1'b0, 0);
    // R11: simultaneous requests, allocation wins
    begin
      bit g; int a;
      expect_free("R10 seed", 0, 40, 1'b1, 0);
      @(negedge clk);
      alloc_req = 1'b1; alloc_size = 16'd40; alloc_policy = 2'b00;
      free_req = 1'b1; free_base = 16'd500; free_size = 16'd10;
      @(negedge clk);
      alloc_req = 1'b0; free_req = 1'b0;
      wait_done(g, a);
      check(g == 1'b1 && a == 0, "R11 alloc priority", a, 0);
    end
    expect_alloc("R11 release dropped", 2'b00, 1'b0, 10, 1'b0, 0);

    summary();
    $finish;
  end

endmodule